// File: doc/BRIEF.md
# Bandwidth Zone Monitor

This block watches a stream of bus transfers and measures how much traffic passes during a sampling window of programmable length. The window length is counted in ticks of an external timer strobe, such as a 19.2 MHz reference divided down or used directly. Each accepted transfer adds its byte count to a saturating accumulator. When the window closes, the total is converted to coarse count units (64-byte units by default). The unit count is then sorted into one of four zones by three thresholds: low, medium and high.

The zone the window lands in selects an 8-bit action field. That field tells each of the four per-zone hit counters whether to increment, clear or hold. A zone raises a one-cycle event when its hit counter is incremented up to that zone's programmed limit, and the counter then re-arms at zero. This allows policies such as "fire after 3 medium-traffic windows in a row, but fire on the first high-traffic window". The block also keeps a peak register for each zone, which holds the largest count that has landed in that zone. A two-bit clear request and an enable complete the control set. Register access and interrupt merging are left to the surrounding logic.

Top module: `bwz_monitor`

## Requirements
- R1: After reset, zone_evt is 0000, every peak in zone_max is 0, and the tick counter, accumulator and hit counters are all zero.
- R2: A window closes on the tick that brings the tick count, counted since the last close, clear or reset, up to win_len. A win_len of 0 behaves as 1.
- R3: The window count is the accumulated byte total shifted right by UNIT_LOG2, which gives 64-byte units by default. A transfer presented in the same cycle as the closing tick belongs to the closing window. The next window starts from zero.
- R4: The byte accumulator saturates at its maximum instead of wrapping, so a heavy window reports the top count of 4095.
- R5: Zones are checked from the top down. The window is zone 3 if count >= thr_hi, else zone 2 if count >= thr_med, else zone 1 if count >= thr_lo, else zone 0. A count equal to a threshold therefore goes to the upper zone.
- R6: When a window lands in zone z, byte z of act_word (bits 8z+7:8z) is applied. In that byte, bits 2k+1:2k act on the hit counter of zone k: 2 increments it (saturating at 255), 1 clears it, and 0 or 3 leave it unchanged.
- R7: If an increment takes zone k's hit counter to a value equal to byte k of hit_lim, zone_evt[k] is high for exactly the one cycle after the closing edge, and that counter returns to zero.
- R8: A hit limit of 0xFF never produces an event, even after the counter saturates.
- R9: zone_max bits 12k+11:12k hold the largest window count that has landed in zone k. The update happens at the closing edge, and the other zones' peaks are left unchanged.
- R10: A cycle with clr_req[0]=1 zeroes the tick counter, the accumulator and all hit counters, but keeps the peaks. If it coincides with a closing tick, the clear wins and no window completes.
- R11: clr_req=11 also zeroes every peak. clr_req=10 has no effect.
- R12: While mon_en is 0, ticks and transfers are ignored, no window closes, no event fires, and the peaks are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Gates all counting |
| clr_req | input | 2 | Bit 0: clear window and hit state; bits 1 and 0 together: also clear peaks |
| tick | input | 1 | Sampling timer strobe |
| xfer_vld | input | 1 | Transfer accepted this cycle |
| xfer_bytes | input | BYTES_W | Bytes moved by the transfer |
| win_len | input | WIN_W | Window length in ticks |
| thr_lo | input | CNT_W | Low threshold, in count units |
| thr_med | input | CNT_W | Medium threshold |
| thr_hi | input | CNT_W | High threshold |
| act_word | input | 32 | Four packed action fields, zone 0 in the low byte |
| hit_lim | input | 32 | Four packed 8-bit hit limits, zone 0 in the low byte |
| zone_evt | output | 4 | One-cycle event per zone |
| zone_max | output | 4*CNT_W | Packed per-zone peak counts, zone 0 in the low bits |

## Verification
The hardest state to reach from the ports is a hit counter that has saturated under a silenced 0xFF limit. Getting there takes more than 255 qualifying windows. The stimulus uses one-tick windows, each carrying a single transfer sized for zone 2, and runs 260 of them back to back. A second case that needs careful timing is a clear request landing on the exact cycle of a closing tick. The stimulus sets a one-tick window and drives both together, then uses a following window's close time to show that the tick counter really restarted. Cross-zone actions, where a zone-0 window increments zone 1, are reached by reprogramming act_word partway through the run.

// File: rtl/bwz_pkg.sv
package bwz_pkg;
    localparam int NZ    = 4;       // zones, fixed by three thresholds
    localparam int ZW    = 2;       // zone index width
    localparam int FLD_W = 8;       // action field / hit limit width
    localparam int HIT_W = 8;       // hit counter width
    localparam logic [HIT_W-1:0] LIM_OFF = '1;   // limit value that silences a zone

    typedef enum logic [1:0] {
        SLOT_HOLD  = 2'd0,
        SLOT_CLR   = 2'd1,
        SLOT_INC   = 2'd2,
        SLOT_HOLD3 = 2'd3
    } slot_e;
endpackage

// File: rtl/bwz_window.sv
module bwz_window #(
    parameter int WIN_W     = 24,
    parameter int BYTES_W   = 16,
    parameter int CNT_W     = 12,
    parameter int UNIT_LOG2 = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               clr_win,
    input  logic               tick,
    input  logic               xfer_vld,
    input  logic [BYTES_W-1:0] xfer_bytes,
    input  logic [WIN_W-1:0]   win_len,
    output logic               win_end,
    output logic [CNT_W-1:0]   win_cnt
);
    localparam int ACC_W = CNT_W + UNIT_LOG2;

    typedef struct packed {
        logic [WIN_W-1:0] ticks;
        logic [ACC_W-1:0] acc;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [ACC_W:0]   sum_w;
    logic [ACC_W-1:0] acc_now;
    logic [WIN_W:0]   tick_next;

    always_comb begin
        sum_w     = {1'b0, st_q.acc}
                  + (xfer_vld ? {{(ACC_W + 1 - BYTES_W){1'b0}}, xfer_bytes} : '0);
        acc_now   = sum_w[ACC_W] ? {ACC_W{1'b1}} : sum_w[ACC_W-1:0];
        tick_next = {1'b0, st_q.ticks} + 1'b1;
        win_end   = en && tick && !clr_win && (tick_next >= {1'b0, win_len});
        win_cnt   = acc_now[ACC_W-1:UNIT_LOG2];

        st_d = st_q;
        if (clr_win) begin
            st_d = '0;
        end else if (en) begin
            if (win_end) begin
                st_d = '0;
            end else begin
                st_d.acc = acc_now;
                if (tick) st_d.ticks = tick_next[WIN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the accumulator only drops at a window close or a clear
    a_r4_acc_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr_win) && !$past(win_end)) |-> st_q.acc >= $past(st_q.acc));

    // R12: with the monitor disabled and no clear, window state is frozen
    a_r12_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en) && !$past(clr_win)) |-> $stable(st_q));

    // R10: a clear leaves the window empty
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_win |=> (st_q.ticks == '0 && st_q.acc == '0));
endmodule

// File: rtl/bwz_classify.sv
module bwz_classify #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] thr_lo,
    input  logic [CNT_W-1:0] thr_med,
    input  logic [CNT_W-1:0] thr_hi,
    output logic [1:0]       zone
);
    always_comb begin
        if (cnt >= thr_hi)       zone = 2'd3;
        else if (cnt >= thr_med) zone = 2'd2;
        else if (cnt >= thr_lo)  zone = 2'd1;
        else                     zone = 2'd0;
    end
endmodule

// File: rtl/bwz_zone_bank.sv
module bwz_zone_bank
    import bwz_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  win_end,
    input  logic [ZW-1:0]         win_zone,
    input  logic [CNT_W-1:0]      win_cnt,
    input  logic [NZ*FLD_W-1:0]   act_word,
    input  logic [NZ*FLD_W-1:0]   hit_lim,
    input  logic                  clr_win,
    input  logic                  clr_all,
    output logic [NZ-1:0]         zone_evt,
    output logic [NZ*CNT_W-1:0]   zone_max
);
    typedef struct packed {
        logic [NZ-1:0][HIT_W-1:0] hits;
        logic [NZ-1:0][CNT_W-1:0] maxv;
        logic [NZ-1:0]            evt;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [FLD_W-1:0] fld;

    always_comb begin : next_state
        logic [HIT_W-1:0] nh;
        logic [HIT_W-1:0] lim;
        slot_e            slot;
        fld   = act_word[win_zone*FLD_W +: FLD_W];
        st_d  = st_q;
        st_d.evt = '0;
        nh    = '0;
        lim   = '0;
        slot  = SLOT_HOLD;
        if (clr_win) begin
            st_d.hits = '0;
            if (clr_all) st_d.maxv = '0;
        end else if (win_end) begin
            if (win_cnt > st_q.maxv[win_zone]) st_d.maxv[win_zone] = win_cnt;
            for (int k = 0; k < NZ; k++) begin
                slot = slot_e'(fld[2*k +: 2]);
                lim  = hit_lim[k*FLD_W +: FLD_W];
                nh   = (st_q.hits[k] == '1) ? st_q.hits[k] : st_q.hits[k] + 1'b1;
                case (slot)
                    SLOT_CLR: st_d.hits[k] = '0;
                    SLOT_INC: begin
                        if (nh == lim && lim != LIM_OFF) begin
                            st_d.evt[k]  = 1'b1;
                            st_d.hits[k] = '0;
                        end else begin
                            st_d.hits[k] = nh;
                        end
                    end
                    default: st_d.hits[k] = st_q.hits[k];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign zone_evt = st_q.evt;

    for (genvar k = 0; k < NZ; k++) begin : g_zone
        assign zone_max[k*CNT_W +: CNT_W] = st_q.maxv[k];

        // R7, R8: an event follows a close and never comes from a silenced limit
        a_r7_evt_after_close: assert property (@(posedge clk) disable iff (!rst_n)
            zone_evt[k] |-> ($past(win_end) && !$past(clr_win)
                             && $past(hit_lim[k*FLD_W +: FLD_W]) != LIM_OFF));

        // R9: peaks never shrink except on a full clear
        a_r9_peak_mono: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(clr_all) |-> st_q.maxv[k] >= $past(st_q.maxv[k]));

        // R9: only the landing zone's peak may move
        a_r9_peak_only_landed: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(win_end) && $past(win_zone) != k && !$past(clr_win))
                |-> $stable(st_q.maxv[k]));

        // R11: a full clear empties every peak
        a_r11_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
            clr_all |=> st_q.maxv[k] == '0);
    end
endmodule

// File: rtl/bwz_monitor.sv
module bwz_monitor
    import bwz_pkg::*;
#(
    parameter int WIN_W     = 24,
    parameter int BYTES_W   = 16,
    parameter int CNT_W     = 12,
    parameter int UNIT_LOG2 = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mon_en,
    input  logic [1:0]           clr_req,
    input  logic                 tick,
    input  logic                 xfer_vld,
    input  logic [BYTES_W-1:0]   xfer_bytes,
    input  logic [WIN_W-1:0]     win_len,
    input  logic [CNT_W-1:0]     thr_lo,
    input  logic [CNT_W-1:0]     thr_med,
    input  logic [CNT_W-1:0]     thr_hi,
    input  logic [NZ*FLD_W-1:0]  act_word,
    input  logic [NZ*FLD_W-1:0]  hit_lim,
    output logic [NZ-1:0]        zone_evt,
    output logic [NZ*CNT_W-1:0]  zone_max
);
    logic             clr_win, clr_all, win_end;
    logic [CNT_W-1:0] win_cnt;
    logic [ZW-1:0]    win_zone;

    assign clr_win = clr_req[0];
    assign clr_all = clr_req[0] & clr_req[1];

    bwz_window #(
        .WIN_W(WIN_W), .BYTES_W(BYTES_W), .CNT_W(CNT_W), .UNIT_LOG2(UNIT_LOG2)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .en(mon_en), .clr_win(clr_win), .tick(tick),
        .xfer_vld(xfer_vld), .xfer_bytes(xfer_bytes), .win_len(win_len),
        .win_end(win_end), .win_cnt(win_cnt)
    );

    bwz_classify #(.CNT_W(CNT_W)) u_classify (
        .cnt(win_cnt), .thr_lo(thr_lo), .thr_med(thr_med), .thr_hi(thr_hi),
        .zone(win_zone)
    );

    bwz_zone_bank #(.CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .win_end(win_end), .win_zone(win_zone),
        .win_cnt(win_cnt), .act_word(act_word), .hit_lim(hit_lim),
        .clr_win(clr_win), .clr_all(clr_all),
        .zone_evt(zone_evt), .zone_max(zone_max)
    );

    // R12: nothing fires in the cycle after a disabled cycle
    a_r12_no_evt_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mon_en) |-> zone_evt == '0);
endmodule

// File: tb/bwz_monitor_tb_top.sv
module bwz_monitor_tb_top;
    localparam int WIN_W = 24, BYTES_W = 16, CNT_W = 12, UNIT_LOG2 = 6;
    localparam int ACC_MAX = (1 << (CNT_W + UNIT_LOG2)) - 1;

    logic clk = 1'b0, rst_n = 1'b0, mon_en = 1'b0, tick = 1'b0, xfer_vld = 1'b0;
    logic [1:0]          clr_req = '0;
    logic [BYTES_W-1:0]  xfer_bytes = '0;
    logic [WIN_W-1:0]    win_len = '0;
    logic [CNT_W-1:0]    thr_lo = 12'd10, thr_med = 12'd20, thr_hi = 12'd40;
    logic [31:0]         act_word = 32'h9525_0901;
    logic [31:0]         hit_lim  = 32'h01FF_03FF;
    logic [3:0]          zone_evt;
    logic [4*CNT_W-1:0]  zone_max;

    always #10 clk = ~clk;

    bwz_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .clr_req(clr_req), .tick(tick),
        .xfer_vld(xfer_vld), .xfer_bytes(xfer_bytes), .win_len(win_len),
        .thr_lo(thr_lo), .thr_med(thr_med), .thr_hi(thr_hi),
        .act_word(act_word), .hit_lim(hit_lim),
        .zone_evt(zone_evt), .zone_max(zone_max)
    );

    typedef struct {
        int                 due;
        logic [3:0]         evt;
        logic [4*CNT_W-1:0] mx;
        string              tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   errors = 0, checks = 0;
    int   hits[4];
    int   mxm[4];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4*CNT_W-1:0] model_max();
        logic [4*CNT_W-1:0] v;
        for (int k = 0; k < 4; k++) v[k*CNT_W +: CNT_W] = mxm[k][CNT_W-1:0];
        return v;
    endfunction

    task automatic report(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Reference model of one window close (R5, R6, R7, R8, R9)
    task automatic close_model(int c, string tag);
        int z, fld, slot, lim, nh;
        exp_t it;
        logic [3:0] ev;
        ev = '0;
        if (c >= int'(thr_hi)) z = 3;
        else if (c >= int'(thr_med)) z = 2;
        else if (c >= int'(thr_lo)) z = 1;
        else z = 0;
        if (c > mxm[z]) mxm[z] = c;
        fld = (act_word >> (8 * z)) & 8'hFF;
        for (int k = 0; k < 4; k++) begin
            slot = (fld >> (2 * k)) & 3;
            lim  = (hit_lim >> (8 * k)) & 8'hFF;
            if (slot == 1) hits[k] = 0;
            else if (slot == 2) begin
                nh = (hits[k] == 255) ? 255 : hits[k] + 1;
                if (nh == lim && lim != 255) begin
                    ev[k] = 1'b1;
                    hits[k] = 0;
                end else hits[k] = nh;
            end
        end
        it.due = cyc + 1;
        it.evt = ev;
        it.mx  = model_max();
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Driver: beats first, then ticks; overlap puts the last beat on the closing tick
    task automatic do_window(int nbeats, int bpb, int nticks, bit overlap, string tag);
        int total, c, pre, eff;
        win_len = WIN_W'(nticks);
        total = nbeats * bpb;
        if (total > ACC_MAX) total = ACC_MAX;
        c   = total >> UNIT_LOG2;
        pre = overlap ? nbeats - 1 : nbeats;
        eff = (nticks == 0) ? 1 : nticks;
        for (int i = 0; i < pre; i++) begin
            @(negedge clk);
            xfer_vld = 1'b1; xfer_bytes = BYTES_W'(bpb); tick = 1'b0;
        end
        for (int t = 0; t < eff; t++) begin
            @(negedge clk);
            tick = 1'b1;
            xfer_vld = overlap && (t == eff - 1);
            xfer_bytes = BYTES_W'(bpb);
            if (t == eff - 1) close_model(c, tag);
        end
        @(negedge clk);
        tick = 1'b0; xfer_vld = 1'b0;
    endtask

    task automatic check_now(string tag);
        @(negedge clk);
        report({tag, " peaks"}, 64'(zone_max), 64'(model_max()));
    endtask

    // Monitor: pops expected results on their due cycle
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0 && sbq[0].due < cyc) begin
                report({sbq[0].tag, " missed close"}, 64'(cyc), 64'(sbq[0].due));
                void'(sbq.pop_front());
            end
            if (sbq.size() > 0 && sbq[0].due == cyc) begin
                report({sbq[0].tag, " events"}, 64'(zone_evt), 64'(sbq[0].evt));
                report({sbq[0].tag, " peaks"},  64'(zone_max), 64'(sbq[0].mx));
                void'(sbq.pop_front());
            end else if (rst_n && zone_evt != 4'b0) begin
                report("R7 R12 unexpected event", 64'(zone_evt), 64'd0);
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(100000 * 20);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 4; k++) begin hits[k] = 0; mxm[k] = 0; end
        repeat (3) @(negedge clk);
        report("R1 reset events", 64'(zone_evt), 64'd0);
        report("R1 reset peaks", 64'(zone_max), 64'd0);
        rst_n = 1'b1; mon_en = 1'b1;

        do_window(5, 64, 4, 0, "R3 zone0 count");
        do_window(2, 320, 4, 0, "R5 equal low goes to zone1");
        do_window(1, 960, 4, 0, "R6 zone1 second hit");
        do_window(4, 640, 4, 0, "R7 equal high zone3 event");
        do_window(2, 384, 4, 0, "R6 zone1 after clear by zone3");
        do_window(2, 384, 4, 0, "R6 zone1 second");
        do_window(2, 384, 4, 0, "R7 zone1 third hit event");
        do_window(2, 640, 4, 1, "R3 R5 closing-cycle transfer to zone2");
        do_window(1, 64, 0, 0, "R2 zero length acts as one");
        do_window(1, 64, 3, 0, "R2 three tick window");
        do_window(5, 65535, 2, 0, "R4 saturated count");

        for (int i = 0; i < 260; i++) do_window(1, 1600, 1, 0, "R8 silenced zone2");

        // R12: disabled traffic and ticks are ignored
        @(negedge clk); mon_en = 1'b0; win_len = 24'd4;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); xfer_vld = 1'b1; xfer_bytes = 16'd640; tick = (i > 0);
        end
        @(negedge clk); xfer_vld = 1'b0; tick = 1'b0;
        check_now("R12 disabled hold");
        mon_en = 1'b1;
        do_window(1, 320, 4, 0, "R12 only enabled traffic counted");

        // R10: partial window then clear restarts ticks and bytes
        do_window(2, 384, 4, 0, "R10 zone1 hit before clear");
        win_len = 24'd4;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); xfer_vld = (i < 3); xfer_bytes = 16'd640; tick = (i >= 3);
        end
        @(negedge clk); xfer_vld = 1'b0; tick = 1'b0; clr_req = 2'b01;
        for (int k = 0; k < 4; k++) hits[k] = 0;
        @(negedge clk); clr_req = 2'b00;
        do_window(1, 448, 4, 0, "R10 window after clear");
        do_window(2, 384, 4, 0, "R10 zone1 hit after clear");
        do_window(2, 384, 4, 0, "R10 zone1 hit two, no event");

        // R10: clear beats a closing tick
        @(negedge clk); win_len = 24'd1; tick = 1'b1; xfer_vld = 1'b1;
        xfer_bytes = 16'd4000; clr_req = 2'b01;
        for (int k = 0; k < 4; k++) hits[k] = 0;
        @(negedge clk); tick = 1'b0; xfer_vld = 1'b0; clr_req = 2'b00;
        check_now("R10 clear wins over close");
        do_window(2, 384, 4, 0, "R10 ticks restarted after clear");

        // R11: bit 1 alone does nothing, both bits clear peaks
        @(negedge clk); clr_req = 2'b10;
        @(negedge clk); clr_req = 2'b00;
        check_now("R11 upper bit alone");
        @(negedge clk); clr_req = 2'b11;
        for (int k = 0; k < 4; k++) begin hits[k] = 0; mxm[k] = 0; end
        @(negedge clk); clr_req = 2'b00;
        check_now("R11 full clear peaks");
        do_window(1, 192, 3, 0, "R9 peak rebuilt after full clear");

        // R6: slot 3 holds, zone0 field increments zone1
        act_word = 32'h9525_090B;
        do_window(1, 128, 2, 0, "R6 cross-zone increment one");
        do_window(1, 128, 2, 0, "R6 cross-zone increment two");
        do_window(1, 128, 2, 0, "R7 cross-zone event");

        repeat (4) @(negedge clk);
        report("R7 scoreboard drained", 64'(sbq.size()), 64'd0);
        finish_run();
    end
endmodule